// File: doc/BRIEF.md
# Flash Page Relocation Engine

This block is a small flash translation engine sitting in front of a modelled flash array. The array holds a number of physical blocks, each split into a fixed number of pages. Every access moves one whole page. A page may only be programmed while it is still in the erased state, so a write to a page that already holds data cannot be done in place. Instead, the engine takes a spare block and erases it. It programs the new page into that block, then copies the other live pages of the old block across. Finally it points the logical block at the new physical block and hands the old one back to the spare pool.

Requests arrive on a valid/ready port carrying a read-or-write flag, a logical block, a page index and write data. Each accepted request produces one response pulse. The pulse carries the page data (the read data, or the data just written), the physical block that served the request and that block's erase count. The erase count of each physical block is tracked for wear. When a spare is needed, the engine takes the spare with the lowest count, so that wear spreads across the array.

Top module: `ftl_engine`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. Logical block i maps to physical block i. Every page reads as all ones, and every erase count is 0. Physical blocks NUM_LOGICAL and up form the spare pool.
- R2: A read that is accepted in cycle n gives a one-cycle `rsp_valid` in cycle n+1. `rsp_rdata` carries the page data, or all ones if the page has not been programmed since its block was last erased.
- R3: A write to a page that has not been programmed is done directly. It gets its response in the next cycle with `rsp_rdata` equal to the written data and `rsp_pblk` equal to the current mapping, and `req_ready` stays 1.
- R4: A write to a page that has already been programmed starts a relocation. `req_ready` is 0 for exactly ERASE_CYCLES + PAGES + 2 cycles after the accepting edge. Requests presented during that time are not taken and leave the array unchanged.
- R5: A relocation erases the chosen spare block before anything is programmed into it, and no page is ever programmed twice between erases. The erase count of that block rises by exactly one, and the new count is reported on `rsp_wear`.
- R6: After a relocation, the new block holds the new data at the written page. Every other page that was programmed in the old block keeps its data. Pages that were never programmed still read as all ones.
- R7: The logical-to-physical map changes only when the relocation completes. From then on, accesses to that logical block are served by the new physical block, and other logical blocks keep their mapping.
- R8: The block that was replaced goes back into the spare pool and can be chosen and erased by a later relocation.
- R9: The spare block chosen is the one with the lowest erase count. On a tie, the lowest block index wins.
- R10: Every accepted request produces exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = page write, 0 = page read |
| req_lblk | input | LBLK_W | Logical block index |
| req_page | input | PAGE_W | Page index within the block |
| req_wdata | input | DATA_W | Page data for a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, or the written data for a write |
| rsp_pblk | output | PBLK_W | Physical block that served the request |
| rsp_wear | output | CNT_W | Erase count of that physical block |

## Verification
The assertions assume that `req_lblk` is always below NUM_LOGICAL and `req_page` below PAGES. They also assume that the spare pool is never empty when a relocation begins, which follows from NUM_LOGICAL being smaller than NUM_BLOCKS. The stimulus uses the default sizes, where every encodable logical index and page index is in range. It raises requests only while `req_ready` is high, except for one deliberate burst during a relocation that checks requests are ignored while busy. The erase counts stay far below saturation, so the increment check always sees a plain plus-one.

// File: rtl/ftl_pkg.sv
// Shared types for the flash relocation engine.
package ftl_pkg;

    // Sequencer states: idle, erase spare, program new page, copy back, commit map.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ERASE  = 3'd1,
        ST_PROG   = 3'd2,
        ST_COPY   = 3'd3,
        ST_COMMIT = 3'd4
    } ftl_state_t;

endpackage

// File: rtl/ftl_erase_timer.sv
// Multi-cycle erase timer.
// Does: after a start pulse, raises done for one cycle ERASE_CYCLES cycles later.
// Assumes: start is only pulsed while no erase is in progress; ERASE_CYCLES >= 1.
module ftl_erase_timer #(
    parameter int ERASE_CYCLES = 6,
    parameter int TW           = $clog2(ERASE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);

    logic          running_q;
    logic [TW-1:0] cnt_q;

    assign done_o = running_q && (cnt_q == '0);

    // Load the cycle budget on start, count down, and stop once done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (start_i) begin
            running_q <= 1'b1;
            cnt_q     <= TW'(ERASE_CYCLES - 1);
        end else if (done_o) begin
            running_q <= 1'b0;
        end else if (running_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !running_q); // R4

endmodule

// File: rtl/ftl_free_pick.sv
// Spare block selector.
// Does: among blocks flagged free, returns the one with the smallest erase
//       count; on equal counts the lowest index is returned.
// Assumes: clk/rst_n are used only to sample the checks below.
module ftl_free_pick #(
    parameter int NUM_BLOCKS = 6,
    parameter int CNT_W      = 8,
    parameter int PBLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BLOCKS-1:0]              free_i,
    input  logic [NUM_BLOCKS-1:0][CNT_W-1:0]   wear_i,
    output logic [PBLK_W-1:0]                  pick_o,
    output logic                               ok_o
);

    logic [CNT_W-1:0] best_cnt;

    // Linear scan: strict less-than keeps the earliest index on a tie.
    always_comb begin
        ok_o     = 1'b0;
        pick_o   = '0;
        best_cnt = '1;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (free_i[i] && (!ok_o || wear_i[i] < best_cnt)) begin
                ok_o     = 1'b1;
                pick_o   = PBLK_W'(i);
                best_cnt = wear_i[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_chk
        AST_PICK_LEAST_WORN: assert property (@(posedge clk) disable iff (!rst_n)
            (ok_o && free_i[g]) |-> (wear_i[g] >= wear_i[pick_o])); // R9
        AST_PICK_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (ok_o && free_i[g] && wear_i[g] == wear_i[pick_o]) |-> (PBLK_W'(g) >= pick_o)); // R9
    end

endmodule

// File: rtl/ftl_page_array.sv
// Modelled flash page store with a per-page programmed bitmap.
// Does: one combinational read port; one page program port; a whole-block
//       erase (all pages to ones, bitmap cleared); a whole-block invalidate
//       (bitmap cleared, data kept).
// Assumes: at most one of program/erase/invalidate per cycle; indices in range.
module ftl_page_array #(
    parameter int NUM_BLOCKS = 6,
    parameter int PAGES      = 4,
    parameter int DATA_W     = 8,
    parameter int PBLK_W     = $clog2(NUM_BLOCKS),
    parameter int PAGE_W     = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PBLK_W-1:0] rd_blk,
    input  logic [PAGE_W-1:0] rd_page,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [PBLK_W-1:0] wr_blk,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              er_en,
    input  logic [PBLK_W-1:0] er_blk,
    input  logic              inv_en,
    input  logic [PBLK_W-1:0] inv_blk
);

    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    logic [DATA_W-1:0] mem_q   [NUM_BLOCKS][PAGES];
    logic [PAGES-1:0]  valid_q [NUM_BLOCKS];

    assign rd_data  = mem_q[rd_blk][rd_page];
    assign rd_valid = valid_q[rd_blk][rd_page];

    // Apply erase, program or invalidate to the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                valid_q[b] <= '0;
                for (int p = 0; p < PAGES; p++) begin
                    mem_q[b][p] <= ERASED;
                end
            end
        end else begin
            if (er_en) begin
                valid_q[er_blk] <= '0;
                for (int p = 0; p < PAGES; p++) begin
                    mem_q[er_blk][p] <= ERASED;
                end
            end
            if (wr_en) begin
                mem_q[wr_blk][wr_page]   <= wr_data;
                valid_q[wr_blk][wr_page] <= 1'b1;
            end
            if (inv_en) begin
                valid_q[inv_blk] <= '0;
            end
        end
    end

    AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid_q[wr_blk][wr_page]); // R5
    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        er_en |=> (valid_q[$past(er_blk)] == '0)); // R5
    AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, er_en, inv_en}) <= 1); // R5

endmodule

// File: rtl/ftl_engine.sv
// Flash translation engine top.
// Does: serves page reads and writes for logical blocks. A write to an already
//       programmed page relocates the block: erase the least worn spare,
//       program the new page, copy back the other live pages, then remap the
//       logical block and return the old block to the spare pool.
// Assumes: NUM_LOGICAL < NUM_BLOCKS, PAGES >= 2, request indices in range.
module ftl_engine #(
    parameter int NUM_BLOCKS   = 6,
    parameter int NUM_LOGICAL  = 4,
    parameter int PAGES        = 4,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 6,
    parameter int CNT_W        = 8,
    parameter int LBLK_W       = $clog2(NUM_LOGICAL),
    parameter int PBLK_W       = $clog2(NUM_BLOCKS),
    parameter int PAGE_W       = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LBLK_W-1:0] req_lblk,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [PBLK_W-1:0] rsp_pblk,
    output logic [CNT_W-1:0]  rsp_wear
);
    import ftl_pkg::*;

    localparam logic [DATA_W-1:0] ERASED    = {DATA_W{1'b1}};
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);

    ftl_state_t state_q;

    logic [LBLK_W-1:0] lblk_q;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] data_q;
    logic [PBLK_W-1:0] old_q;
    logic [PBLK_W-1:0] new_q;
    logic [PAGE_W-1:0] copy_q;

    logic [NUM_LOGICAL-1:0][PBLK_W-1:0] map_q;
    logic [NUM_BLOCKS-1:0]              free_q;
    logic [NUM_BLOCKS-1:0][CNT_W-1:0]   wear_q;

    logic [PBLK_W-1:0] cur_pblk;
    logic              accept;
    logic              relocate;

    logic [PBLK_W-1:0] pa_rd_blk;
    logic [PAGE_W-1:0] pa_rd_page;
    logic [DATA_W-1:0] pa_rd_data;
    logic              pa_rd_valid;
    logic              pa_wr_en;
    logic [PBLK_W-1:0] pa_wr_blk;
    logic [PAGE_W-1:0] pa_wr_page;
    logic [DATA_W-1:0] pa_wr_data;
    logic              pa_er_en;
    logic              pa_inv_en;

    logic [PBLK_W-1:0] pick_blk;
    logic              pick_ok;
    logic              tmr_done;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cur_pblk  = map_q[req_lblk];
    assign relocate  = accept && req_write && pa_rd_valid;
    assign pa_er_en  = (state_q == ST_ERASE) && tmr_done;
    assign pa_inv_en = (state_q == ST_COMMIT);

    // Steer the page store read and program ports by sequencer state.
    always_comb begin
        pa_rd_blk  = cur_pblk;
        pa_rd_page = req_page;
        pa_wr_en   = 1'b0;
        pa_wr_blk  = new_q;
        pa_wr_page = page_q;
        pa_wr_data = data_q;
        case (state_q)
            ST_IDLE: begin
                if (accept && req_write && !pa_rd_valid) begin
                    pa_wr_en   = 1'b1;
                    pa_wr_blk  = cur_pblk;
                    pa_wr_page = req_page;
                    pa_wr_data = req_wdata;
                end
            end
            ST_PROG: begin
                pa_wr_en = 1'b1;
            end
            ST_COPY: begin
                pa_rd_blk  = old_q;
                pa_rd_page = copy_q;
                pa_wr_page = copy_q;
                pa_wr_data = pa_rd_data;
                pa_wr_en   = (copy_q != page_q) && pa_rd_valid;
            end
            default: ;
        endcase
    end

    // Sequencer: accept requests, run erase/program/copy/commit, emit responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lblk_q    <= '0;
            page_q    <= '0;
            data_q    <= '0;
            old_q     <= '0;
            new_q     <= '0;
            copy_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_pblk  <= '0;
            rsp_wear  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lblk_q <= req_lblk;
                        page_q <= req_page;
                        data_q <= req_wdata;
                        if (relocate) begin
                            old_q   <= cur_pblk;
                            new_q   <= pick_blk;
                            state_q <= ST_ERASE;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_pblk  <= cur_pblk;
                            rsp_wear  <= wear_q[cur_pblk];
                            rsp_rdata <= req_write ? req_wdata
                                       : (pa_rd_valid ? pa_rd_data : ERASED);
                        end
                    end
                end
                ST_ERASE: begin
                    if (tmr_done) state_q <= ST_PROG;
                end
                ST_PROG: begin
                    copy_q  <= '0;
                    state_q <= ST_COPY;
                end
                ST_COPY: begin
                    if (copy_q == LAST_PAGE) state_q <= ST_COMMIT;
                    else                     copy_q  <= copy_q + 1'b1;
                end
                ST_COMMIT: begin
                    rsp_valid <= 1'b1;
                    rsp_pblk  <= new_q;
                    rsp_wear  <= wear_q[new_q];
                    rsp_rdata <= data_q;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Mapping, spare pool and wear counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOGICAL; i++) map_q[i] <= PBLK_W'(i);
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                free_q[b] <= (b >= NUM_LOGICAL);
                wear_q[b] <= '0;
            end
        end else begin
            if (pa_er_en && wear_q[new_q] != '1) begin
                wear_q[new_q] <= wear_q[new_q] + 1'b1;
            end
            if (state_q == ST_COMMIT) begin
                map_q[lblk_q] <= new_q;
                free_q[new_q] <= 1'b0;
                free_q[old_q] <= 1'b1;
            end
        end
    end

    ftl_page_array #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES), .DATA_W(DATA_W),
        .PBLK_W(PBLK_W), .PAGE_W(PAGE_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(pa_rd_blk), .rd_page(pa_rd_page),
        .rd_data(pa_rd_data), .rd_valid(pa_rd_valid),
        .wr_en(pa_wr_en), .wr_blk(pa_wr_blk), .wr_page(pa_wr_page), .wr_data(pa_wr_data),
        .er_en(pa_er_en), .er_blk(new_q),
        .inv_en(pa_inv_en), .inv_blk(old_q)
    );

    ftl_free_pick #(
        .NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W), .PBLK_W(PBLK_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .free_i(free_q), .wear_i(wear_q),
        .pick_o(pick_blk), .ok_o(pick_ok)
    );

    ftl_erase_timer #(
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_i(relocate), .done_o(tmr_done)
    );

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid); // R2
    AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |-> (!req_ready && !rsp_valid)); // R4
    AST_SPARE_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        relocate |-> pick_ok); // R9
    AST_WEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_er_en && wear_q[new_q] != '1) |=> (wear_q[new_q] == $past(wear_q[new_q]) + 1'b1)); // R5
    AST_COMMIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (rsp_valid && rsp_pblk == map_q[$past(lblk_q)])); // R7

    for (genvar g = 0; g < NUM_LOGICAL; g++) begin : g_map_chk
        AST_MAPPED_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_IDLE) |-> !free_q[map_q[g]]); // R8
    end

endmodule

// File: tb/tb_ftl_engine.sv
// Directed bench for ftl_engine: one task per scenario.
module tb_ftl_engine;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic       req_write;
    logic [1:0] req_lblk;
    logic [1:0] req_page;
    logic [7:0] req_wdata;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic [2:0] rsp_pblk;
    logic [7:0] rsp_wear;

    int checks   = 0;
    int failures = 0;
    int acc_cnt  = 0;
    int rsp_cnt  = 0;
    bit done     = 0;

    localparam int RELOC_BUSY = 6 + 4 + 2;

    always #5 clk = ~clk;

    ftl_engine dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_lblk(req_lblk), .req_page(req_page), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_pblk(rsp_pblk), .rsp_wear(rsp_wear)
    );

    // Count handshakes and response pulses at the ports.
    always @(posedge clk) begin
        if (rst_n && req_valid && req_ready) acc_cnt++;
        if (rst_n && rsp_valid) rsp_cnt++;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Issue one request; optionally drive a competing request while busy.
    task automatic issue(input logic wr, input logic [1:0] lb, input logic [1:0] pg,
                         input logic [7:0] d, input bit ign,
                         output logic [7:0] rd, output logic [2:0] pb,
                         output logic [7:0] wear, output int busy);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lblk = lb; req_page = pg; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        n = 0;
        while (!rsp_valid && n < 100) begin
            if (!req_ready) busy++;
            if (ign && n == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_lblk = 2'd2;
                req_page = 2'd0; req_wdata = 8'h77;
            end
            if (ign && n == 5) req_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        rd = rsp_rdata; pb = rsp_pblk; wear = rsp_wear;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] lb, input logic [1:0] pg,
                          input logic [7:0] exp_d, input logic [2:0] exp_pb);
        logic [7:0] rd, wear; logic [2:0] pb; int busy;
        issue(1'b0, lb, pg, 8'h00, 1'b0, rd, pb, wear, busy);
        chk(tag, $sformatf("read l%0d p%0d data", lb, pg), rd, exp_d);
        chk(tag, $sformatf("read l%0d p%0d pblk", lb, pg), pb, exp_pb);
    endtask

    task automatic wr_chk(input string tag, input logic [1:0] lb, input logic [1:0] pg,
                          input logic [7:0] d, input bit ign, input int exp_busy,
                          input logic [2:0] exp_pb, input logic [7:0] exp_wear);
        logic [7:0] rd, wear; logic [2:0] pb; int busy;
        issue(1'b1, lb, pg, d, ign, rd, pb, wear, busy);
        chk(tag, "write busy cycles", busy, exp_busy);
        chk(tag, "write echo data", rd, d);
        chk(tag, "write pblk", pb, exp_pb);
        chk(tag, "write wear", wear, exp_wear);
    endtask

    // R1 reset state, R2 reads of unprogrammed pages.
    task automatic t_reset();
        logic [7:0] rd, wear; logic [2:0] pb; int busy;
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "rsp_valid after reset", rsp_valid, 0);
        for (int i = 0; i < 4; i++) begin
            issue(1'b0, 2'(i), 2'd0, 8'h00, 1'b0, rd, pb, wear, busy);
            chk("R1", "identity pblk", pb, i);
            chk("R1", "initial wear", wear, 0);
            chk("R2", "erased page reads ones", rd, 8'hFF);
            chk("R2", "read has no busy time", busy, 0);
        end
    endtask

    // R3 direct programming of unprogrammed pages.
    task automatic t_direct();
        wr_chk("R3", 2'd0, 2'd1, 8'h11, 1'b0, 0, 3'd0, 8'd0);
        wr_chk("R3", 2'd0, 2'd2, 8'h22, 1'b0, 0, 3'd0, 8'd0);
        rd_chk("R2", 2'd0, 2'd1, 8'h11, 3'd0);
        rd_chk("R2", 2'd0, 2'd2, 8'h22, 3'd0);
    endtask

    // R4 R5 R6 R7 first relocation into spare block 4.
    task automatic t_relocate();
        wr_chk("R4", 2'd0, 2'd1, 8'h5A, 1'b0, RELOC_BUSY, 3'd4, 8'd1);
        rd_chk("R7", 2'd0, 2'd1, 8'h5A, 3'd4);
        rd_chk("R6", 2'd0, 2'd2, 8'h22, 3'd4);
        rd_chk("R6", 2'd0, 2'd0, 8'hFF, 3'd4);
        rd_chk("R6", 2'd0, 2'd3, 8'hFF, 3'd4);
        rd_chk("R7", 2'd3, 2'd0, 8'hFF, 3'd3);
    endtask

    // R8 R9 old block reused on a tie; copy-back again.
    task automatic t_reuse();
        wr_chk("R8", 2'd0, 2'd2, 8'h33, 1'b0, RELOC_BUSY, 3'd0, 8'd1);
        rd_chk("R6", 2'd0, 2'd1, 8'h5A, 3'd0);
        rd_chk("R6", 2'd0, 2'd2, 8'h33, 3'd0);
    endtask

    // R9 least worn spare wins over a lower index; R4 busy requests ignored.
    task automatic t_wear_and_ignore();
        wr_chk("R3", 2'd1, 2'd0, 8'h44, 1'b0, 0, 3'd1, 8'd0);
        wr_chk("R9", 2'd1, 2'd0, 8'h45, 1'b1, RELOC_BUSY, 3'd5, 8'd1);
        rd_chk("R4", 2'd2, 2'd0, 8'hFF, 3'd2);
        rd_chk("R7", 2'd1, 2'd0, 8'h45, 3'd5);
    endtask

    // R5 a second erase of the same block counts up to two.
    task automatic t_second_erase();
        wr_chk("R9", 2'd0, 2'd2, 8'h34, 1'b0, RELOC_BUSY, 3'd1, 8'd1);
        wr_chk("R5", 2'd0, 2'd1, 8'h66, 1'b0, RELOC_BUSY, 3'd0, 8'd2);
        rd_chk("R6", 2'd0, 2'd2, 8'h34, 3'd0);
        rd_chk("R6", 2'd0, 2'd1, 8'h66, 3'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_lblk = '0; req_page = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_relocate();
        t_reuse();
        t_wear_and_ignore();
        t_second_erase();
        @(negedge clk);
        chk("R10", "responses equal accepted requests", rsp_cnt, acc_cnt);
        finish_run();
    end

endmodule